// File: doc/BRIEF.md
# PCI Inbound Access Mode Gate

This block sits beside the bus interface of a PCI-style port. For each inbound request it decides whether to acknowledge it, retry it or master-abort it. It also decides whether the port may start transactions of its own as bus master. Its decisions rest on four control bits:

- a personality bit (host or agent)
- a configuration hold bit
- a bus-master enable
- a memory-space enable

Two strap inputs, sampled only while reset is held, choose one of three power-on personalities and load the reset values of these bits. After reset, two write paths update the bits. The local processor side writes the hold bit. The configuration side writes the bus-master and memory-space enables.

The bus protocol, address decoding and the data paths belong to neighbouring logic. That logic raises a one-cycle request strobe with a configuration/memory flag and receives a 2-bit response code one clock later.

Top module: `pci_access_gate`

## Requirements
- R1: With `strap_agent` = 0 at reset release (host personality), `agent_mode` = 0, `master_en` = 1, `mem_en` = 0 and `hold_state` = 0.
- R2: With `strap_agent` = 1 and `strap_hold` = 0 at reset release (plain agent), `agent_mode` = 1, `hold_state` = 0, `master_en` = 0 and `mem_en` = 0.
- R3: With `strap_agent` = 1 and `strap_hold` = 1 at reset release (agent with configuration hold), `agent_mode` = 1, `hold_state` = 1, `master_en` = 0 and `mem_en` = 0.
- R4: Strap inputs are sampled only while `rst_n` is low. Changes to them after reset release leave all control bits unchanged.
- R5: In host personality, every inbound configuration request gets response 11 (master abort), whatever `hold_state` holds. A local write to the hold bit in host personality is stored and shows on `hold_state`, but it does not change the responses.
- R6: In agent personality with `hold_state` = 0, an inbound configuration request gets response 01 (acknowledge).
- R7: In agent personality with `hold_state` = 1, an inbound configuration request gets response 10 (retry). A local write to the hold bit affects only requests in later cycles. A request in the same cycle as a clearing write is still retried, and the next one is acknowledged.
- R8: In any personality, an inbound memory request gets 01 when `mem_en` = 1 and 11 when `mem_en` = 0.
- R9: `rsp_code` is registered. It carries the code for a request exactly one cycle after the cycle in which `req_valid` was sampled high, and it is 00 in any cycle after a cycle without a request.
- R10: A configuration write sets `master_en` and `mem_en` to the written values from the next cycle on. `out_allow` is high only when `out_req` is high and `master_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| strap_agent | input | 1 | Personality strap: 0 = host, 1 = agent |
| strap_hold | input | 1 | Agent only: 1 = start with configuration hold set |
| lcl_wr_en | input | 1 | Local-side write strobe for the hold bit |
| lcl_wr_hold | input | 1 | Value written to the hold bit |
| cfg_wr_en | input | 1 | Configuration-side write strobe for the enables |
| cfg_wr_master | input | 1 | Value written to the bus-master enable |
| cfg_wr_mem | input | 1 | Value written to the memory-space enable |
| req_valid | input | 1 | Inbound request strobe, one cycle per request |
| req_is_cfg | input | 1 | 1 = configuration request, 0 = memory request |
| out_req | input | 1 | Port wants to start an outbound transaction |
| rsp_code | output | 2 | 00 none, 01 acknowledge, 10 retry, 11 master abort |
| out_allow | output | 1 | Outbound start permitted |
| agent_mode | output | 1 | Current personality bit (1 = agent) |
| hold_state | output | 1 | Current configuration hold bit |
| master_en | output | 1 | Current bus-master enable |
| mem_en | output | 1 | Current memory-space enable |

## Verification
A response code is due one clock edge after the edge that samples its request. The control-bit outputs change one edge after a write strobe. `out_allow` follows `out_req` within the same cycle. The bench drives inputs on falling edges and queues each expected code when it raises a request. A monitor records `req_valid` at the next rising edge, waits 2 ns, and pops and compares the code, or expects 00 when no request was sampled. Register values are read one full cycle after their write strobe, and `out_allow` is read a nanosecond after `out_req` changes.

// File: rtl/pci_gate_pkg.sv
// Package: shared response encoding, control-bit bundle and power-on
// value function for the inbound access gate.
// Assumes: responses are 2 bits wide and encoded as listed below.
package pci_gate_pkg;

    localparam int RSP_W = 2;

    typedef enum logic [RSP_W-1:0] {
        RSP_NONE  = 2'b00,
        RSP_ACK   = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_ABORT = 2'b11
    } rsp_e;

    typedef struct packed {
        logic agent;       // 1 = agent personality, 0 = host
        logic hold;        // configuration hold (retry) bit
        logic bus_master;  // outbound mastering enable
        logic mem_space;   // inbound memory acknowledge enable
    } ctrl_s;

    // Power-on values of the control bits for the strapped personality.
    function automatic ctrl_s por_values(input logic agent_strap,
                                         input logic hold_strap);
        ctrl_s v;
        v.agent      = agent_strap;
        v.hold       = agent_strap & hold_strap;
        v.bus_master = ~agent_strap;
        v.mem_space  = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/pci_gate_ctrl.sv
// Module: control-bit register file of the access gate.
// Loads the strapped power-on values while reset is low, then accepts
// local-side hold writes and configuration-side enable writes.
// Assumes: synchronous active-low reset; the two write paths touch
// disjoint bits, so they may fire in the same cycle.
module pci_gate_ctrl
    import pci_gate_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strap_agent,
    input  logic  strap_hold,
    input  logic  lcl_wr_en,
    input  logic  lcl_wr_hold,
    input  logic  cfg_wr_en,
    input  logic  cfg_wr_master,
    input  logic  cfg_wr_mem,
    output ctrl_s ctrl
);

    ctrl_s ctrl_q;

    // Personality bit: follows the strap only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q.agent <= por_values(strap_agent, strap_hold).agent;
    end

    // Hold bit: strapped at reset, written from the local side afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q.hold <= por_values(strap_agent, strap_hold).hold;
        else if (lcl_wr_en) ctrl_q.hold <= lcl_wr_hold;
    end

    // Enables: strapped at reset, written from the configuration side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.bus_master <= por_values(strap_agent, strap_hold).bus_master;
            ctrl_q.mem_space  <= por_values(strap_agent, strap_hold).mem_space;
        end else if (cfg_wr_en) begin
            ctrl_q.bus_master <= cfg_wr_master;
            ctrl_q.mem_space  <= cfg_wr_mem;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/pci_gate_resp.sv
// Module: inbound response decision and output register.
// Chooses acknowledge, retry or master abort from the current control
// bits and registers the code so it appears one cycle after the strobe.
// Assumes: control bits are register outputs, so a write in the request
// cycle is not yet visible to that request.
module pci_gate_resp
    import pci_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_s            ctrl,
    input  logic             req_valid,
    input  logic             req_is_cfg,
    output logic [RSP_W-1:0] rsp_code
);

    rsp_e cfg_rsp, mem_rsp, next_rsp;
    logic [RSP_W-1:0] rsp_q;

    // Configuration request: host aborts, agent retries while held.
    always_comb begin
        if (!ctrl.agent)    cfg_rsp = RSP_ABORT;
        else if (ctrl.hold) cfg_rsp = RSP_RETRY;
        else                cfg_rsp = RSP_ACK;
    end

    // Memory request: acknowledged only with memory space enabled.
    always_comb begin
        mem_rsp = ctrl.mem_space ? RSP_ACK : RSP_ABORT;
    end

    // Select the code for this cycle's request, none when idle.
    always_comb begin
        if (!req_valid)      next_rsp = RSP_NONE;
        else if (req_is_cfg) next_rsp = cfg_rsp;
        else                 next_rsp = mem_rsp;
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= RSP_NONE;
        else        rsp_q <= next_rsp;
    end

    assign rsp_code = rsp_q;

endmodule

// File: rtl/pci_access_gate.sv
// Module: top of the inbound access mode gate.
// Joins the control-bit registers, the response decision and the
// outbound permission gate, and exposes the control bits.
// Assumes: neighbouring logic presents at most one request per cycle.
module pci_access_gate
    import pci_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_agent,
    input  logic       strap_hold,
    input  logic       lcl_wr_en,
    input  logic       lcl_wr_hold,
    input  logic       cfg_wr_en,
    input  logic       cfg_wr_master,
    input  logic       cfg_wr_mem,
    input  logic       req_valid,
    input  logic       req_is_cfg,
    input  logic       out_req,
    output logic [1:0] rsp_code,
    output logic       out_allow,
    output logic       agent_mode,
    output logic       hold_state,
    output logic       master_en,
    output logic       mem_en
);

    ctrl_s ctrl;

    pci_gate_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_agent   (strap_agent),
        .strap_hold    (strap_hold),
        .lcl_wr_en     (lcl_wr_en),
        .lcl_wr_hold   (lcl_wr_hold),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_master (cfg_wr_master),
        .cfg_wr_mem    (cfg_wr_mem),
        .ctrl          (ctrl)
    );

    pci_gate_resp u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .req_valid  (req_valid),
        .req_is_cfg (req_is_cfg),
        .rsp_code   (rsp_code)
    );

    // Outbound permission: only with bus mastering enabled.
    always_comb begin
        out_allow = out_req & ctrl.bus_master;
    end

    assign agent_mode = ctrl.agent;
    assign hold_state = ctrl.hold;
    assign master_en  = ctrl.bus_master;
    assign mem_en     = ctrl.mem_space;

endmodule

// File: rtl/pci_access_gate_chk.sv
// Checker: temporal properties of the access gate, bound to its top.
// Assumes: observes only top-level ports.
module pci_access_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       strap_agent,
    input logic       req_valid,
    input logic       req_is_cfg,
    input logic       out_req,
    input logic [1:0] rsp_code,
    input logic       out_allow,
    input logic       agent_mode,
    input logic       hold_state,
    input logic       master_en,
    input logic       mem_en
);

    p_host_por_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !agent_mode) |-> (master_en && !mem_en && !hold_state));

    p_agent_por_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && agent_mode) |-> (!master_en && !mem_en));

    p_strap_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (agent_mode == $past(strap_agent)));

    p_mode_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(agent_mode));

    p_host_cfg_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_cfg && !agent_mode) |=> (rsp_code == 2'b11));

    p_agent_cfg_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_cfg && agent_mode && !hold_state) |=> (rsp_code == 2'b01));

    p_agent_cfg_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_cfg && agent_mode && hold_state) |=> (rsp_code == 2'b10));

    p_mem_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_cfg && mem_en) |=> (rsp_code == 2'b01));

    p_mem_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_cfg && !mem_en) |=> (rsp_code == 2'b11));

    p_idle_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (rsp_code == 2'b00));

    p_out_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_allow |-> (out_req && master_en));

endmodule

bind pci_access_gate pci_access_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_agent (strap_agent),
    .req_valid   (req_valid),
    .req_is_cfg  (req_is_cfg),
    .out_req     (out_req),
    .rsp_code    (rsp_code),
    .out_allow   (out_allow),
    .agent_mode  (agent_mode),
    .hold_state  (hold_state),
    .master_en   (master_en),
    .mem_en      (mem_en)
);

// File: tb/pci_access_gate_test.sv
module pci_access_gate_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_agent = 1'b0, strap_hold = 1'b0;
    logic lcl_wr_en = 1'b0, lcl_wr_hold = 1'b0;
    logic cfg_wr_en = 1'b0, cfg_wr_master = 1'b0, cfg_wr_mem = 1'b0;
    logic req_valid = 1'b0, req_is_cfg = 1'b0, out_req = 1'b0;
    logic [1:0] rsp_code;
    logic out_allow, agent_mode, hold_state, master_en, mem_en;

    int tests = 0;
    int fails = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;  // 125 MHz

    pci_access_gate uut (.*);

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Monitor: compares the response one edge after each sampled strobe.
    always @(posedge clk) begin
        logic sampled, live;
        sampled = req_valid;
        live    = rst_n;
        #2;
        if (live) begin
            if (sampled) begin
                if (exp_q.size() == 0) chk("R9 unexpected", rsp_code, 2'b00);
                else chk(tag_q.pop_front(), rsp_code, exp_q.pop_front());
            end else begin
                chk("R9 idle", rsp_code, 2'b00);
            end
        end
    end

    task automatic do_reset(logic agent, logic hold);
        @(negedge clk);
        rst_n = 1'b0; strap_agent = agent; strap_hold = hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strap_agent = ~agent; strap_hold = ~hold;  // must be ignored
    endtask

    // Driver: one request strobe, optional same-cycle local hold write.
    task automatic send(logic is_cfg, logic [1:0] exp, string tag,
                        logic clr_hold = 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_is_cfg = is_cfg;
        lcl_wr_en = clr_hold; lcl_wr_hold = 1'b0;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0; lcl_wr_en = 1'b0;
    endtask

    task automatic cfg_write(logic m, logic s);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_master = m; cfg_wr_mem = s;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic lcl_write(logic h);
        @(negedge clk);
        lcl_wr_en = 1'b1; lcl_wr_hold = h;
        @(negedge clk);
        lcl_wr_en = 1'b0;
    endtask

    task automatic out_probe(logic [1:0] exp, string tag);
        @(negedge clk);
        out_req = 1'b1;
        #1 chk(tag, {1'b0, out_allow}, exp);
        out_req = 1'b0;
    endtask

    initial begin
        // Host personality, hold strap high must not matter.
        do_reset(1'b0, 1'b1);
        chk("R1 agent", {1'b0, agent_mode}, 2'b00);
        chk("R1 master", {1'b0, master_en}, 2'b01);
        chk("R1 mem", {1'b0, mem_en}, 2'b00);
        chk("R1 hold", {1'b0, hold_state}, 2'b00);
        repeat (3) @(negedge clk);
        chk("R4 agent after strap change", {1'b0, agent_mode}, 2'b00);
        chk("R4 master after strap change", {1'b0, master_en}, 2'b01);
        send(1'b1, 2'b11, "R5 host cfg");
        lcl_write(1'b1);
        chk("R5 host hold stored", {1'b0, hold_state}, 2'b01);
        send(1'b1, 2'b11, "R5 host cfg with hold");
        send(1'b0, 2'b11, "R8 mem disabled");
        cfg_write(1'b1, 1'b1);
        chk("R10 mem set", {1'b0, mem_en}, 2'b01);
        send(1'b0, 2'b01, "R8 mem enabled");
        out_probe(2'b01, "R10 host out allowed");

        // Plain agent.
        do_reset(1'b1, 1'b0);
        chk("R2 agent", {1'b0, agent_mode}, 2'b01);
        chk("R2 hold", {1'b0, hold_state}, 2'b00);
        chk("R2 master", {1'b0, master_en}, 2'b00);
        chk("R2 mem", {1'b0, mem_en}, 2'b00);
        repeat (2) @(negedge clk);
        chk("R4 hold after strap change", {1'b0, hold_state}, 2'b00);
        out_probe(2'b00, "R10 agent out blocked");
        send(1'b1, 2'b01, "R6 agent cfg ack");
        send(1'b0, 2'b11, "R8 agent mem disabled");
        cfg_write(1'b1, 1'b1);
        chk("R10 master set", {1'b0, master_en}, 2'b01);
        out_probe(2'b01, "R10 agent out allowed");
        send(1'b0, 2'b01, "R8 agent mem enabled");
        cfg_write(1'b0, 1'b0);
        send(1'b0, 2'b11, "R8 mem cleared again");

        // Agent with configuration hold.
        do_reset(1'b1, 1'b1);
        chk("R3 agent", {1'b0, agent_mode}, 2'b01);
        chk("R3 hold", {1'b0, hold_state}, 2'b01);
        chk("R3 master", {1'b0, master_en}, 2'b00);
        chk("R3 mem", {1'b0, mem_en}, 2'b00);
        send(1'b1, 2'b10, "R7 held cfg retry");
        send(1'b1, 2'b10, "R7 same-cycle clear still retry", 1'b1);
        chk("R7 hold cleared", {1'b0, hold_state}, 2'b00);
        send(1'b1, 2'b01, "R7 ack after clear");
        send(1'b0, 2'b11, "R8 held agent mem");
        lcl_write(1'b1);
        send(1'b1, 2'b10, "R7 hold set again");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("R9 pending responses", 2'(exp_q.size()), 2'b00);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule